// File: doc/BRIEF.md
# Serial EEPROM two-wire target engine

This block is the bus-facing half of a serial EEPROM. It lives in a system clock domain and watches SCL and SDA after an upstream synchronizer. From these two lines it finds start and stop conditions and checks the device address byte against its own select pins. On a write it takes a two-byte memory address and hands each accepted data byte to a write engine. On a read it shifts bytes out of storage. It only ever pulls SDA low, through an open-drain enable.

A single address counter serves both directions. A selective read, which is a write of the address followed by a repeated start, loads the counter. A read with no address continues from the byte after the last one touched. Sequential reads wrap from the top of memory to zero, and written bytes wrap inside a page of `2**PAGE_W` bytes. The write engine reports a running internal write on `busy_i`. While it is high the engine refuses its own address, so a controller can poll until the write is done. A write-protect level is latched once per write transaction.

The state machine has eleven states:
- `ST_IDLE` ignores the bus until a start.
- `ST_DEV` receives the device byte, then goes to `ST_DEV_ACK` on a match or back to `ST_IDLE` on a mismatch.
- `ST_DEV_ACK` goes to `ST_RDAT` for a read or `ST_AHI` for a write.
- The address path runs `ST_AHI` → `ST_AHI_ACK` → `ST_ALO` → `ST_ALO_ACK` → `ST_WDAT`.
- The write loop runs `ST_WDAT` → `ST_WDAT_ACK` → `ST_WDAT`. When protected it goes from `ST_WDAT` to `ST_IDLE` instead.
- The read loop runs `ST_RDAT` → `ST_RD_ACK` → `ST_RDAT` while the controller acknowledges, or → `ST_IDLE` on a not-acknowledge.
- Every transition happens on an SCL falling edge. A start from any state goes to `ST_DEV`, and a stop from any state goes to `ST_IDLE`.

Top module: `eep_i2c_target`

## Requirements
- R1: Out of reset `sda_oe` and `wr_en` are 0. Until a start condition (SDA falling while SCL is high) is seen, clocked bus traffic draws no acknowledge and no write. A stop condition (SDA rising while SCL is high) returns the engine to idle.
- R2: The device byte is acknowledged only when its upper seven bits equal binary 1010 followed by `dev_sel[2:0]`. Bit 0 selects the direction: 1 means read, 0 means write. On a mismatch nothing more is acknowledged until the next start.
- R3: The target pulls SDA low for the whole ninth clock after the device byte, after both address bytes and after each accepted write byte. Each accepted write byte gives a one-cycle `wr_en` carrying `wr_addr` and `wr_data`.
- R4: While `busy_i` is high at the end of the device byte, the device byte is not acknowledged.
- R5: `wp_i` is latched on the SCL falling edge that ends the acknowledge of the second address byte. If it is latched high, the first data byte is not acknowledged, no `wr_en` or `wr_go` is produced, and storage is left unchanged.
- R6: Bits are captured on SCL rising edges. `sda_oe` never changes while SCL is high.
- R7: A read with no address returns the byte at the counter. The counter points one past the last byte read or written.
- R8: Two address bytes, then a repeated start, then a read, return data starting at the address sent. The address is the lower `ADDR_W` bits of the 16-bit address word; the bits above are ignored.
- R9: Read bytes continue at successive addresses while the controller acknowledges. A not-acknowledge ends the read. The address after `2**ADDR_W-1` is 0.
- R10: Successive write bytes go to successive addresses. Only the low `PAGE_W` address bits count, so the address wraps within its page.
- R11: A stop that follows at least one accepted write byte gives a one-cycle `wr_go`. Any other stop gives none.
- R12: A start in the middle of a byte restarts device-byte reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level (wired bus value) |
| sda_oe | output | 1 | 1 pulls SDA low |
| dev_sel | input | 3 | Device select pins |
| wp_i | input | 1 | Write-protect level |
| busy_i | input | 1 | Internal write in progress |
| wr_en | output | 1 | Write-byte strobe to the write engine |
| wr_addr | output | ADDR_W | Address of the strobed byte |
| wr_data | output | 8 | Strobed byte |
| wr_go | output | 1 | Start the internal write cycle |
| rd_addr | output | ADDR_W | Storage read address (the counter) |
| rd_data | input | 8 | Storage byte at `rd_addr` |

## Verification
Every action starts from a bus edge that the engine sees one clock after the pin moves. `sda_oe` therefore settles within two clocks of an SCL fall, and `wr_en` and `wr_go` appear one clock after the eighth falling edge or after the stop. The bench holds each SCL phase for four clocks. It samples acknowledges and read bits two clocks into the SCL high phase, long after `sda_oe` has settled. It counts strobes at falling clock edges and reads the counts only after the transaction's stop.

// File: rtl/eep_tgt_pkg.sv
package eep_tgt_pkg;
    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DEV, ST_DEV_ACK, ST_AHI, ST_AHI_ACK, ST_ALO,
        ST_ALO_ACK, ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_RD_ACK
    } tgt_state_t;
endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        scl_rise  = scl_i & ~scl_q;
        scl_fall  = ~scl_i & scl_q;
        start_det = scl_i & scl_q & sda_q & ~sda_i;
        stop_det  = scl_i & scl_q & ~sda_q & sda_i;
    end
endmodule

// File: rtl/eep_addr_ctr.sv
module eep_addr_ctr #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step_seq,
    input  logic              step_page,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int PW = (PAGE_W < ADDR_W) ? PAGE_W : ADDR_W;
    localparam logic [ADDR_W-1:0] ONE_A = 1;
    localparam logic [PW-1:0]     ONE_P = 1;

    logic [ADDR_W-1:0] ctr;
    logic [ADDR_W-1:0] page_next;

    generate
        if (PW == ADDR_W) begin : g_flat
            assign page_next = ctr + ONE_A;
        end else begin : g_paged
            assign page_next = {ctr[ADDR_W-1:PW], ctr[PW-1:0] + ONE_P};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ctr <= '0;
        else if (load)      ctr <= load_val;
        else if (step_page) ctr <= page_next;
        else if (step_seq)  ctr <= ctr + ONE_A;
    end

    assign addr_o = ctr;
endmodule

// File: rtl/eep_i2c_target.sv
module eep_i2c_target #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        dev_sel,
    input  logic              wp_i,
    input  logic              busy_i,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_go,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data
);
    import eep_tgt_pkg::*;

    localparam int HI_W = ADDR_W - 8;

    tgt_state_t        state, nxt;
    logic              scl_rise, scl_fall, start_det, stop_det;
    logic [7:0]        shreg;
    logic [3:0]        bcnt;
    logic [HI_W-1:0]   hi_q;
    logic              wp_q, wrote_q, mack_q;
    logic              ctr_load, ctr_seq, ctr_page;
    logic [ADDR_W-1:0] ctr;
    logic              byte_done, dev_hit, rx_state;

    i2c_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    eep_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val({hi_q, shreg}),
        .step_seq(ctr_seq), .step_page(ctr_page), .addr_o(ctr)
    );

    assign byte_done = scl_fall && (bcnt == 4'd8);
    assign dev_hit   = (shreg[7:1] == {DEV_PREFIX, dev_sel}) && !busy_i;
    assign rx_state  = (state == ST_DEV) || (state == ST_AHI) ||
                       (state == ST_ALO) || (state == ST_WDAT);

    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_DEV;
        end else if (scl_fall) begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_DEV:      if (bcnt == 4'd8) nxt = dev_hit ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:  nxt = shreg[0] ? ST_RDAT : ST_AHI;
                ST_AHI:      if (bcnt == 4'd8) nxt = ST_AHI_ACK;
                ST_AHI_ACK:  nxt = ST_ALO;
                ST_ALO:      if (bcnt == 4'd8) nxt = ST_ALO_ACK;
                ST_ALO_ACK:  nxt = ST_WDAT;
                ST_WDAT:     if (bcnt == 4'd8) nxt = wp_q ? ST_IDLE : ST_WDAT_ACK;
                ST_WDAT_ACK: nxt = ST_WDAT;
                ST_RDAT:     if (bcnt == 4'd7) nxt = ST_RD_ACK;
                ST_RD_ACK:   nxt = mack_q ? ST_RDAT : ST_IDLE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bcnt    <= '0;
            hi_q    <= '0;
            wp_q    <= 1'b0;
            wrote_q <= 1'b0;
            mack_q  <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            wr_go   <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            wr_go <= 1'b0;
            if (stop_det) begin
                bcnt    <= '0;
                wr_go   <= wrote_q;
                wrote_q <= 1'b0;
            end else if (start_det) begin
                bcnt <= '0;
            end else if (scl_rise) begin
                if (rx_state) begin
                    shreg <= {shreg[6:0], sda_i};
                    bcnt  <= bcnt + 4'd1;
                end
                if (state == ST_RD_ACK) mack_q <= !sda_i;
            end else if (scl_fall) begin
                if (rx_state && bcnt == 4'd8) bcnt <= '0;
                if (state == ST_AHI && bcnt == 4'd8) hi_q <= shreg[HI_W-1:0];
                if (state == ST_ALO_ACK) wp_q <= wp_i;
                if (state == ST_WDAT && bcnt == 4'd8 && !wp_q) begin
                    wr_en   <= 1'b1;
                    wr_addr <= ctr;
                    wr_data <= shreg;
                    wrote_q <= 1'b1;
                end
                if ((state == ST_DEV_ACK && shreg[0]) || (state == ST_RD_ACK && mack_q)) begin
                    shreg <= rd_data;
                    bcnt  <= '0;
                end
                if (state == ST_RDAT) begin
                    shreg <= {shreg[6:0], 1'b1};
                    bcnt  <= (bcnt == 4'd7) ? 4'd0 : bcnt + 4'd1;
                end
            end
        end
    end

    always_comb begin
        ctr_load = byte_done && (state == ST_ALO) && !stop_det && !start_det;
        ctr_page = byte_done && (state == ST_WDAT) && !wp_q && !stop_det && !start_det;
        ctr_seq  = scl_fall && (state == ST_RDAT) && (bcnt == 4'd7);
        unique case (state)
            ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: sda_oe = 1'b1;
            ST_RDAT:                                          sda_oe = !shreg[7];
            default:                                          sda_oe = 1'b0;
        endcase
        rd_addr = ctr;
    end
endmodule

// File: rtl/eep_i2c_target_chk.sv
module eep_i2c_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe,
    input logic busy_i,
    input logic wr_en,
    input logic wr_go,
    input logic wp_q,
    input logic stop_det,
    input logic in_dev_ack
);
    p_busy_nack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_dev_ack) && $past(busy_i) |-> !sda_oe);

    p_oe_quiet_scl_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        scl_i && $past(scl_i) |-> $stable(sda_oe));

    p_wr_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    p_protect_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !wp_q);

    p_go_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> !wr_go);

    p_go_after_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> $past(stop_det));
endmodule

bind eep_i2c_target eep_i2c_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .busy_i(busy_i),
    .wr_en(wr_en), .wr_go(wr_go), .wp_q(wp_q), .stop_det(stop_det),
    .in_dev_ack(state == eep_tgt_pkg::ST_DEV_ACK)
);

// File: tb/eep_i2c_target_bench.sv
module eep_i2c_target_bench;
    localparam int AW   = 9;
    localparam int PW   = 4;
    localparam int MSZ  = 1 << AW;
    localparam int Q    = 4;
    localparam int BUSY = 400;
    localparam logic [7:0] DW = 8'hAA;
    localparam logic [7:0] DR = 8'hAB;

    logic clk = 1'b0;
    logic rst_n, scl, sda_m, wp, busy_i;
    logic sda_oe, sda_line, wr_en, wr_go;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;
    logic [7:0] mem [0:MSZ-1];
    logic [7:0] exp_m [0:MSZ-1];
    int vectors = 0, fails = 0, n_wr = 0, n_go = 0, n_glitch = 0, busy_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign rd_data  = mem[rd_addr];

    eep_i2c_target #(.ADDR_W(AW), .PAGE_W(PW)) u_eep_i2c_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .dev_sel(3'b101), .wp_i(wp), .busy_i(busy_i), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_go(wr_go),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    initial begin
        logic scl_p, oe_p;
        scl_p = 1'b1; oe_p = 1'b0; busy_i = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1) begin
                if (wr_en) begin mem[wr_addr] = wr_data; n_wr++; end
                if (wr_go) begin n_go++; busy_cnt = BUSY; end
                else if (busy_cnt > 0) busy_cnt--;
                busy_i = (busy_cnt != 0);
                if (scl && scl_p && (sda_oe != oe_p)) n_glitch++;
            end
            scl_p = scl; oe_p = sda_oe;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(2);
        end
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        put_bits(b, 8);
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(2);
        acked = !sda_line; tick(2); scl = 1'b0; tick(2);
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl = 1'b1; tick(2); b[i] = sda_line; tick(2); scl = 1'b0; tick(2);
        end
        sda_m = !give_ack; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(2);
        sda_m = 1'b1;
    endtask

    task automatic sel_read(input logic [7:0] hi, input logic [7:0] lo, input int n, input string tag);
        logic a; logic [7:0] b; int base;
        base = {hi[AW-9:0], lo};
        bus_start;
        put_byte(DW, a); chk(a, "R3 device ack", a, 1);
        put_byte(hi, a); chk(a, "R3 high address ack", a, 1);
        put_byte(lo, a); chk(a, "R3 low address ack", a, 1);
        bus_start;
        put_byte(DR, a); chk(a, "R8 read device ack", a, 1);
        for (int k = 0; k < n; k++) begin
            get_byte(k < n - 1, b);
            chk(b == exp_m[(base + k) % MSZ], tag, b, exp_m[(base + k) % MSZ]);
        end
        bus_stop;
    endtask

    task automatic imm_read(input int ptr, input string tag);
        logic a; logic [7:0] b;
        bus_start;
        put_byte(DR, a); chk(a, "R7 read device ack", a, 1);
        get_byte(1'b0, b); chk(b == exp_m[ptr], tag, b, exp_m[ptr]);
        bus_stop;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic a; logic [7:0] b; int w0, g0;
        scl = 1'b1; sda_m = 1'b1; wp = 1'b0; rst_n = 1'b0;
        for (int i = 0; i < MSZ; i++) begin
            mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
            exp_m[i] = mem[i];
        end
        tick(5);
        chk(!sda_oe && !wr_en, "R1 reset state", {sda_oe, wr_en}, 0);
        rst_n = 1'b1; tick(5);

        // R1: clocked traffic with no start is ignored
        scl = 1'b0; tick(Q);
        put_byte(DW, a); chk(!a, "R1 no start no ack", a, 0);
        put_byte(8'h00, a); chk(!a, "R1 no start no ack", a, 0);
        scl = 1'b1; tick(Q);
        bus_stop;
        chk(n_wr == 0 && n_go == 0, "R1 no write", n_wr, 0);

        // R3/R10/R11: six bytes from 0x3C wrap inside a 16-byte page
        bus_start;
        put_byte(DW, a); chk(a, "R3 device ack", a, 1);
        put_byte(8'h00, a); chk(a, "R3 high address ack", a, 1);
        put_byte(8'h3C, a); chk(a, "R3 low address ack", a, 1);
        for (int i = 0; i < 6; i++) begin
            put_byte(8'hC0 + 8'(i), a); chk(a, "R3 data ack", a, 1);
            exp_m[(8'h3C & ~(2**PW - 1)) | ((8'h3C + i) & (2**PW - 1))] = 8'hC0 + 8'(i);
        end
        bus_stop;
        tick(2);
        chk(n_wr == 6, "R3 write strobes", n_wr, 6);
        chk(n_go == 1, "R11 commit after stop", n_go, 1);

        // R4: polled while busy, then after busy ends
        bus_start;
        put_byte(DW, a); chk(!a, "R4 busy nack", a, 0);
        bus_stop;
        tick(BUSY + 50);
        bus_start;
        put_byte(DW, a); chk(a, "R4 ready ack", a, 1);
        bus_stop;
        chk(n_go == 1, "R11 no commit without data", n_go, 1);

        sel_read(8'h00, 8'h3C, 4, "R10 page tail");
        sel_read(8'h00, 8'h30, 2, "R10 page wrap");
        imm_read(9'h032, "R7 counter after read");

        sel_read(8'h00, 8'h10, 5, "R9 sequential");
        imm_read(9'h015, "R7 counter continues");

        // R8/R9: don't-care high bits, wrap from top of memory
        sel_read(8'hFF, 8'hFE, 3, "R9 wrap to zero");
        imm_read(9'h001, "R7 after wrap");

        // R5: write protect latched before first data byte
        w0 = n_wr; g0 = n_go;
        wp = 1'b1;
        bus_start;
        put_byte(DW, a); chk(a, "R5 device ack", a, 1);
        put_byte(8'h00, a); chk(a, "R5 high address ack", a, 1);
        put_byte(8'h20, a); chk(a, "R5 low address ack", a, 1);
        put_byte(8'h55, a); chk(!a, "R5 protected data nack", a, 0);
        bus_stop;
        wp = 1'b0;
        tick(4);
        chk(n_wr == w0, "R5 no strobe", n_wr, w0);
        chk(n_go == g0, "R11 no commit when protected", n_go, g0);
        sel_read(8'h00, 8'h20, 1, "R5 storage unchanged");

        // R12: start in the middle of a byte
        bus_start;
        put_bits(8'hF0, 4);
        bus_start;
        put_byte(DR, a); chk(a, "R12 restart device ack", a, 1);
        get_byte(1'b0, b); chk(b == exp_m[9'h021], "R12 read after restart", b, exp_m[9'h021]);
        bus_stop;

        // R2: sweep of select values plus a wrong prefix
        for (int s = 0; s < 8; s++) begin
            bus_start;
            put_byte({4'b1010, 3'(s), 1'b0}, a);
            chk(a == (s == 5), "R2 select match", a, (s == 5));
            if (s != 5) begin
                put_byte(DW, a); chk(!a, "R2 ignored after mismatch", a, 0);
            end
            bus_stop;
        end
        bus_start;
        put_byte(8'hBA, a); chk(!a, "R2 prefix mismatch", a, 0);
        bus_stop;

        chk(n_glitch == 0, "R6 sda_oe quiet while SCL high", n_glitch, 0);
        chk(n_wr == 6, "R3 total strobes", n_wr, 6);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule